// File: doc/BRIEF.md
# Filtered External Event Counter

This block counts transitions on an asynchronous event input rather than clock cycles. The input first crosses into the clock domain through a short synchronizer chain. After that it is sampled only on cycles where a sample-enable strobe is high, and a change of level counts as an edge only when two strobes in a row see it. This rejects glitches that are shorter than one strobe period.

An edge-select field chooses which transitions count. A 16-bit counter advances on each accepted edge and is compared against a programmable limit. When the counter holds the limit and a further edge arrives, the counter returns to zero. At the same time a one-cycle interrupt pulse is raised and the timer output pin inverts.

The block counts only while the run control is high and the mode field selects event counting. At any other time the counter, the arming state, the filter and the output are held in their cleared state. The first accepted edge after counting starts only arms the counter. Because of this, the first interrupt needs two more edges than the limit, and every later interrupt needs one more edge than the limit.

Top module: `evt_counter`

## Requirements
- R1: Only accepted edges of the kind chosen by `edge_sel` advance the count: 2'b00 falling, 2'b01 rising, 2'b10 none, 2'b11 both.
- R2: A level on `evt_in` that is not seen on two consecutive `smp_en` strobes is never counted.
- R3: The input is sampled only on cycles with `smp_en` high. With no strobe, input changes have no effect and `irq` stays low on the following cycle.
- R4: The first `irq` after counting starts follows `cmp_val` + 2 accepted edges.
- R5: Every later `irq` follows `cmp_val` + 1 further accepted edges, and the counter restarts from zero at each match.
- R6: `irq` is high for exactly one clock per match.
- R7: `tout` inverts on every match, in the same cycle that `irq` rises, and does not change at any other time while counting.
- R8: Counting happens only when `mode` is 2'b11. Mode 2'b10 (restart on an input edge) and every other mode count nothing, raise no `irq`, and hold `tout` low.
- R9: While `run` is low, or while `rst` is high, `tout` and `irq` are low, and the counter, its arming state and the filter are cleared. After a restart the R4 rule applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Prescaler strobe that marks the sampling cycles |
| evt_in | input | 1 | Asynchronous external event input |
| mode | input | 2 | Operating mode; 2'b11 counts events |
| edge_sel | input | 2 | Valid-edge choice (see R1) |
| cmp_val | input | 16 | Compare limit |
| run | input | 1 | Start (1) / stop (0) |
| irq | output | 1 | One-cycle match interrupt pulse |
| tout | output | 1 | Timer output, toggled on each match |

## Verification
The checker checks the following on every clock. It checks that `irq` is one cycle wide. It checks that `irq` never follows a cycle without a strobe, and never follows a cycle in which mode 2'b10 was selected. It checks that `tout` moves only together with `irq`, apart from being cleared to low. It checks that stopping forces both outputs low.

The edge arithmetic can only be shown by the bench's scenarios, which compare the outputs against a model driven by long edge sequences. This covers the extra arming edge before the first match, the limit-plus-one spacing after it, glitch rejection and the filtering by edge choice.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        MODE_HOLD0   = 2'b00,
        MODE_HOLD1   = 2'b01,
        MODE_EXT_CLR = 2'b10,
        MODE_EVENT   = 2'b11
    } mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_ok(edge_sel_e sel, edge_ev_t ev);
        case (sel)
            EDGE_FALL: return ev.fall;
            EDGE_RISE: return ev.rise;
            EDGE_BOTH: return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/evc_filter.sv
module evc_filter
    import evc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     smp_en,
    input  logic     din,
    output edge_ev_t ev
);
    logic samp_q;
    logic lvl_q;

    always_comb begin
        ev = '0;
        if (smp_en && !clr && din == samp_q && din != lvl_q) begin
            ev.rise = din;
            ev.fall = ~din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else if (clr) begin
            // while idle the filter follows the input, so a restart sees no stale edge
            samp_q <= din;
            lvl_q  <= din;
        end else if (smp_en) begin
            samp_q <= din;
            if (ev.rise || ev.fall) lvl_q <= din;
        end
    end
endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             hit,
    input  logic [CNT_W-1:0] cmp,
    output logic             match,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    assign match = active && hit && armed_q && (cnt_q == cmp);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= match;
            if (hit) begin
                if (!armed_q)   armed_q <= 1'b1;
                else if (match) cnt_q   <= '0;
                else            cnt_q   <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/evc_outctl.sv
module evc_outctl (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic match,
    output logic tout
);
    always_ff @(posedge clk) begin
        if (rst || !active) tout <= 1'b0;
        else if (match)     tout <= ~tout;
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic             evt_in,
    input  logic [1:0]       mode,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             run,
    output logic             irq,
    output logic             tout
);
    logic     evt_s;
    edge_ev_t ev;
    logic     active;
    logic     hit;
    logic     match;

    assign active = run && (mode_e'(mode) == MODE_EVENT);
    assign hit    = edge_ok(edge_sel_e'(edge_sel), ev);

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(evt_in), .dout(evt_s)
    );

    evc_filter u_filt (
        .clk(clk), .rst(rst), .clr(!active), .smp_en(smp_en), .din(evt_s), .ev(ev)
    );

    evc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .active(active), .hit(hit),
        .cmp(cmp_val), .match(match), .irq(irq)
    );

    evc_outctl u_out (
        .clk(clk), .rst(rst), .active(active), .match(match), .tout(tout)
    );
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_en,
    input logic       run,
    input logic [1:0] mode,
    input logic       irq,
    input logic       tout
);
    // R6
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R3
    irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !irq);

    // R8
    ext_clr_mode_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> !irq);

    // R7
    tout_flips_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tout != $past(tout)));

    // R7
    tout_quiet_otherwise_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq && tout != $past(tout)) |-> !tout);

    // R9
    stop_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!tout && !irq));
endmodule

bind evt_counter evt_counter_chk u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .run(run),
    .mode(mode), .irq(irq), .tout(tout)
);

// File: tb/evt_counter_test.sv
module evt_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic        evt_in = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [1:0]  edge_sel = 2'b01;
    logic [15:0] cmp_val = 16'd0;
    logic        run = 1'b0;
    logic        irq;
    logic        tout;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;
    bit gate = 1'b1;
    int phase = 0;
    bit prev_irq = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit lvl = 1'b0;
    bit m_armed = 1'b0;
    int m_cnt = 0;
    int m_irqs = 0;
    bit m_tout = 1'b0;
    bit m_first = 1'b1;

    evt_counter uut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .evt_in(evt_in), .mode(mode),
        .edge_sel(edge_sel), .cmp_val(cmp_val), .run(run), .irq(irq), .tout(tout)
    );

    always #5 clk = ~clk;

    // strobe every third cycle
    always @(negedge clk) begin
        phase  = (phase == 2) ? 0 : phase + 1;
        smp_en = gate && (phase == 0);
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // irq pulse monitor, R6 width
    always @(negedge clk) begin
        if (!rst && irq) begin
            irq_seen++;
            if (prev_irq) chk("R6 irq width", 2, 1);
        end
        prev_irq = irq;
    end

    function automatic bit model_active();
        return run && (mode == 2'b11);
    endfunction

    function automatic bit edge_valid(bit rising);
        case (edge_sel)
            2'b00: return !rising;
            2'b01: return rising;
            2'b11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_clear();
        m_armed = 0; m_cnt = 0; m_tout = 0; m_first = 1;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle();
        string req;
        req = "R1";
        @(negedge clk);
        lvl = !lvl;
        evt_in = lvl;
        wait_n(15);
        if (model_active() && gate && edge_valid(lvl)) begin
            if (!m_armed) m_armed = 1;
            else if (m_cnt == int'(cmp_val)) begin
                m_cnt = 0; m_irqs++; m_tout = !m_tout;
                req = m_first ? "R4" : "R5";
                m_first = 0;
            end else m_cnt++;
        end
        chk({req, " irq count"}, irq_seen, m_irqs);
        chk("R7 tout", int'(tout), int'(m_tout));
    endtask

    task automatic glitch();
        @(negedge clk);
        evt_in = !lvl;
        @(negedge clk);
        evt_in = lvl;
        wait_n(15);
        chk("R2 glitch irq count", irq_seen, m_irqs);
    endtask

    task automatic set_run(bit v);
        @(negedge clk);
        run = v;
        wait_n(8);
        if (!model_active()) model_clear();
    endtask

    task automatic set_mode(logic [1:0] v);
        @(negedge clk);
        mode = v;
        wait_n(8);
        if (!model_active()) model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        wait_n(5);
        chk("R9 reset irq", int'(irq), 0);
        chk("R9 reset tout", int'(tout), 0);
        @(negedge clk) rst = 1'b0;
        wait_n(4);

        // R4/R5: limit 2, rising edges
        cmp_val = 16'd2; edge_sel = 2'b01;
        set_run(1);
        for (int i = 0; i < 20; i++) toggle();

        // R2: glitches are rejected
        for (int i = 0; i < 4; i++) glitch();

        // R3: no strobes, even number of toggles
        gate = 1'b0;
        for (int i = 0; i < 6; i++) toggle();
        chk("R3 no strobe irq count", irq_seen, m_irqs);
        gate = 1'b1;
        wait_n(10);
        for (int i = 0; i < 6; i++) toggle();

        // R8: mode 10 and 00 count nothing
        set_mode(2'b10);
        chk("R8 tout low", int'(tout), 0);
        for (int i = 0; i < 8; i++) toggle();
        set_mode(2'b00);
        for (int i = 0; i < 4; i++) toggle();
        set_mode(2'b11);

        // R9: stop clears, restart needs limit+2 again
        for (int i = 0; i < 3; i++) toggle();
        set_run(0);
        chk("R9 stop tout", int'(tout), 0);
        for (int i = 0; i < 3; i++) toggle();
        set_run(1);
        for (int i = 0; i < 12; i++) toggle();

        // boundary: limit 0, both edges
        set_run(0);
        cmp_val = 16'd0; edge_sel = 2'b11;
        set_run(1);
        for (int i = 0; i < 8; i++) toggle();

        // R1: reserved select counts nothing
        set_run(0);
        edge_sel = 2'b10;
        set_run(1);
        for (int i = 0; i < 6; i++) toggle();

        // constrained random rounds
        for (int r = 0; r < 8; r++) begin
            set_run(0);
            cmp_val  = 16'($urandom_range(0, 4));
            edge_sel = 2'($urandom_range(0, 3));
            set_run(1);
            for (int i = 0; i < 18; i++) begin
                if ($urandom_range(0, 4) == 0) glitch();
                toggle();
            end
        end

        set_run(0);
        chk("R9 final tout", int'(tout), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule